// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block slows a processor by driving its active-low suspend input through a repeating two-phase pattern. In the run phase the output is high and the processor executes. In the idle phase the output is low and the processor stops. Each phase lasts a programmed number of 32 µs ticks, and the ticks come from a prescaler on the system clock. The effective processor rate is therefore the full rate times run / (run + idle).

Software sets up the block through a byte-wide register bus. The bus carries a run count, an idle count, a suspend control byte, a power-management enable byte and two speedup hold times. Interrupt events and video-access events can each suspend throttling for a programmed number of milliseconds, so the processor answers them at full speed. Throttling resumes afterwards, starting with a run phase.

Top module: `susp_throttle`

## Requirements
- R1: After reset every register reads 0x00, suspN is 1, and activeIdle and isaClkStop are 0.
- R2: A write stores the data byte at offset 0x80 (power enable), 0x8C (interrupt hold, ms), 0x8D (video hold, ms), 0x94 (run count), 0x95 (idle count) or 0x96 (suspend control), and a read of that offset returns it. Any other offset reads 0x00, and writes to other offsets change no register.
- R3: Modulation runs only when bit 0 of suspend control and bit 0 of power enable are both 1. Otherwise suspN stays 1.
- R4: With both counts nonzero and no hold active, suspN is 1 for run×TICK_DIV clocks and 0 for idle×TICK_DIV clocks, alternating.
- R5: A run count of 0 with a nonzero idle count holds suspN at 0 continuously. An idle count of 0 holds suspN at 1 continuously.
- R6: New count values take effect only at the end of a full run+idle period. A period already in progress completes with the old values.
- R7: When bit 3 of power enable is 1, an irqEvent pulse loads the interrupt hold timer from offset 0x8C. While that timer is nonzero, suspN is 1, starting the cycle after the event. The timer counts down once per MS_TICKS ticks.
- R8: When bit 4 of power enable is 1, a vidEvent pulse does the same with the video hold timer, loaded from offset 0x8D.
- R9: An event whose enable bit (bit 3 for irqEvent, bit 4 for vidEvent) is 0 has no effect on suspN.
- R10: An enabled event that arrives while its hold timer is running reloads the timer with the full programmed value.
- R11: When the last hold timer expires, modulation restarts with a complete run phase of run×TICK_DIV clocks, using the counts latched at that moment.
- R12: activeIdle follows bit 4 of suspend control, and isaClkStop follows bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register offset for read and write |
| regWdata | input | 8 | Write data |
| regWr | input | 1 | Write strobe, one clock per byte |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| irqEvent | input | 1 | Interrupt activity pulse |
| vidEvent | input | 1 | Video access pulse |
| suspN | output | 1 | Active-low suspend to the processor |
| activeIdle | output | 1 | Active-idle power-save request |
| isaClkStop | output | 1 | Request to stop the ISA clock |

## Verification
Several properties are checked on every cycle:
- suspN stays high whenever either enable bit is clear.
- An enabled event with a nonzero hold time forces suspN high on the following cycle.
- A hold timer can only grow in the cycle after an enabled event.
- The latched counts change only on a tick edge or while modulation is stopped.

Other properties depend on exact phase lengths measured in clocks, so only the bench scenarios can show them:
- the full sweep of run and idle counts;
- the old-period-then-new-period sequence after a mid-period write;
- hold windows that are reloaded and then end in a complete run phase.

// File: rtl/thr_pkg.sv
package thr_pkg;

  localparam logic [7:0] ADDR_PMEN   = 8'h80;
  localparam logic [7:0] ADDR_IRQTM  = 8'h8C;
  localparam logic [7:0] ADDR_VIDTM  = 8'h8D;
  localparam logic [7:0] ADDR_RUNCNT = 8'h94;
  localparam logic [7:0] ADDR_IDLCNT = 8'h95;
  localparam logic [7:0] ADDR_SUSCTL = 8'h96;

  localparam int BIT_GLOBAL   = 0;
  localparam int BIT_IRQSPD   = 3;
  localparam int BIT_VIDSPD   = 4;
  localparam int BIT_MODEN    = 0;
  localparam int BIT_ISASTOP  = 3;
  localparam int BIT_ACTIDLE  = 4;

  typedef struct packed {
    logic [7:0] pmEn;
    logic [7:0] irqHold;
    logic [7:0] vidHold;
    logic [7:0] runCnt;
    logic [7:0] idleCnt;
    logic [7:0] susCtl;
  } thrRegs_t;

  typedef struct packed {
    logic modEn;
    logic irqLoad;
    logic vidLoad;
  } thrStrobe_t;

  typedef enum logic {PH_RUN = 1'b0, PH_IDLE = 1'b1} thrPhase_t;

endpackage

// File: rtl/thr_ctrl.sv
module thr_ctrl
  import thr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       regWr,
  output logic [7:0] regRdata,
  input  logic       irqEvent,
  input  logic       vidEvent,
  output thrRegs_t   regs,
  output thrStrobe_t strobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_PMEN:   regs.pmEn    <= regWdata;
        ADDR_IRQTM:  regs.irqHold <= regWdata;
        ADDR_VIDTM:  regs.vidHold <= regWdata;
        ADDR_RUNCNT: regs.runCnt  <= regWdata;
        ADDR_IDLCNT: regs.idleCnt <= regWdata;
        ADDR_SUSCTL: regs.susCtl  <= regWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_PMEN:   regRdata = regs.pmEn;
      ADDR_IRQTM:  regRdata = regs.irqHold;
      ADDR_VIDTM:  regRdata = regs.vidHold;
      ADDR_RUNCNT: regRdata = regs.runCnt;
      ADDR_IDLCNT: regRdata = regs.idleCnt;
      ADDR_SUSCTL: regRdata = regs.susCtl;
      default:     regRdata = 8'h00;
    endcase
  end

  // Strobes towards the datapath
  always_comb begin
    strobe.modEn   = regs.susCtl[BIT_MODEN] & regs.pmEn[BIT_GLOBAL];
    strobe.irqLoad = irqEvent & regs.pmEn[BIT_IRQSPD];
    strobe.vidLoad = vidEvent & regs.pmEn[BIT_VIDSPD];
  end

endmodule

// File: rtl/thr_speedup.sv
module thr_speedup #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          load,
  input  logic [CW-1:0] loadVal,
  output logic [CW-1:0] count
);

  // A load wins over a countdown in the same cycle, so a repeat event restarts the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (msTick && count != '0) begin
      count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/thr_dp.sv
module thr_dp
  import thr_pkg::*;
#(
  parameter int TICK_DIV = 1067,
  parameter int MS_TICKS = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  thrRegs_t   regs,
  input  thrStrobe_t strobe,
  output logic       suspN,
  output logic       tick,
  output logic       run,
  output logic [7:0] runL,
  output logic [7:0] idleL,
  output logic [7:0] irqTimer,
  output logic [7:0] vidTimer
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam int NCH = 2;

  logic [PW-1:0] preCnt;
  logic [MW-1:0] msCnt;
  logic          msTick;

  assign tick   = (preCnt == PW'(TICK_DIV - 1));
  assign msTick = tick && (msCnt == MW'(MS_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + PW'(1);
      if (tick) msCnt <= msTick ? '0 : msCnt + MW'(1);
    end
  end

  // Speedup hold timers: channel 0 interrupt, channel 1 video
  logic [NCH-1:0]       chLoad;
  logic [NCH-1:0][7:0]  chVal;
  logic [NCH-1:0][7:0]  chCount;
  logic [NCH-1:0]       chBusy;

  assign chLoad = {strobe.vidLoad, strobe.irqLoad};
  assign chVal  = {regs.vidHold, regs.irqHold};

  for (genvar g = 0; g < NCH; g++) begin : gTmr
    thr_speedup #(.CW(8)) uTmr (
      .clk    (clk),
      .rstN   (rstN),
      .msTick (msTick),
      .load   (chLoad[g]),
      .loadVal(chVal[g]),
      .count  (chCount[g])
    );
    assign chBusy[g] = (chCount[g] != 8'd0);
  end

  assign irqTimer = chCount[0];
  assign vidTimer = chCount[1];
  assign run      = strobe.modEn && !(|chBusy);

  // Phase sequencer
  thrPhase_t phase;
  logic [7:0] phCnt;
  logic       runDone;
  logic       idleDone;
  thrPhase_t  startPh;

  assign runDone  = (runL == 8'd0) || (phCnt == runL - 8'd1);
  assign idleDone = (phCnt == idleL - 8'd1);
  assign startPh  = (regs.runCnt == 8'd0 && regs.idleCnt != 8'd0) ? PH_IDLE : PH_RUN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_RUN;
      phCnt <= '0;
      runL  <= '0;
      idleL <= '0;
    end else if (!run) begin
      phase <= startPh;
      phCnt <= '0;
      runL  <= regs.runCnt;
      idleL <= regs.idleCnt;
    end else if (tick) begin
      if (phase == PH_RUN) begin
        if (runDone) begin
          if (idleL != 8'd0) begin
            phase <= PH_IDLE;
            phCnt <= '0;
          end else begin
            phase <= startPh;
            phCnt <= '0;
            runL  <= regs.runCnt;
            idleL <= regs.idleCnt;
          end
        end else begin
          phCnt <= phCnt + 8'd1;
        end
      end else begin
        if (idleDone) begin
          phase <= startPh;
          phCnt <= '0;
          runL  <= regs.runCnt;
          idleL <= regs.idleCnt;
        end else begin
          phCnt <= phCnt + 8'd1;
        end
      end
    end
  end

  assign suspN = !(run && phase == PH_IDLE);

endmodule

// File: rtl/susp_throttle.sv
module susp_throttle
  import thr_pkg::*;
#(
  parameter int TICK_DIV = 1067,
  parameter int MS_TICKS = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       regWr,
  output logic [7:0] regRdata,
  input  logic       irqEvent,
  input  logic       vidEvent,
  output logic       suspN,
  output logic       activeIdle,
  output logic       isaClkStop
);

  thrRegs_t   regs;
  thrStrobe_t strobe;
  logic       tick;
  logic       run;
  logic [7:0] runL;
  logic [7:0] idleL;
  logic [7:0] irqTimer;
  logic [7:0] vidTimer;

  thr_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regWr   (regWr),
    .regRdata(regRdata),
    .irqEvent(irqEvent),
    .vidEvent(vidEvent),
    .regs    (regs),
    .strobe  (strobe)
  );

  thr_dp #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .regs    (regs),
    .strobe  (strobe),
    .suspN   (suspN),
    .tick    (tick),
    .run     (run),
    .runL    (runL),
    .idleL   (idleL),
    .irqTimer(irqTimer),
    .vidTimer(vidTimer)
  );

  assign activeIdle = regs.susCtl[BIT_ACTIDLE];
  assign isaClkStop = regs.susCtl[BIT_ISASTOP];

endmodule

// File: rtl/thr_chk.sv
module thr_chk
  import thr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       suspN,
  input logic       irqEvent,
  input logic       vidEvent,
  input thrRegs_t   regs,
  input logic       tick,
  input logic       run,
  input logic [7:0] runL,
  input logic [7:0] idleL,
  input logic [7:0] irqTimer,
  input logic [7:0] vidTimer
);

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(regs.susCtl[BIT_MODEN] && regs.pmEn[BIT_GLOBAL]) |-> suspN);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvent && regs.pmEn[BIT_IRQSPD] && regs.irqHold != 8'd0) |=> suspN);

  assert_vid_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (vidEvent && regs.pmEn[BIT_VIDSPD] && regs.vidHold != 8'd0) |=> suspN);

  assert_irq_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqTimer > $past(irqTimer)) |-> $past(irqEvent && regs.pmEn[BIT_IRQSPD]));

  assert_vid_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vidTimer > $past(vidTimer)) |-> $past(vidEvent && regs.pmEn[BIT_VIDSPD]));

  assert_latch_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(tick)) |-> ($stable(runL) && $stable(idleL)));

endmodule

bind susp_throttle thr_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .suspN   (suspN),
  .irqEvent(irqEvent),
  .vidEvent(vidEvent),
  .regs    (regs),
  .tick    (tick),
  .run     (run),
  .runL    (runL),
  .idleL   (idleL),
  .irqTimer(irqTimer),
  .vidTimer(vidTimer)
);

// File: tb/sim_susp_throttle.sv
`timescale 1ns/1ps
module sim_susp_throttle;

  localparam int TD = 4;
  localparam int MT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWdata = 8'h00;
  logic       regWr = 1'b0;
  logic [7:0] regRdata;
  logic       irqEvent = 1'b0;
  logic       vidEvent = 1'b0;
  logic       suspN;
  logic       activeIdle;
  logic       isaClkStop;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  susp_throttle #(.TICK_DIV(TD), .MS_TICKS(MT)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRdata(regRdata), .irqEvent(irqEvent),
    .vidEvent(vidEvent), .suspN(suspN), .activeIdle(activeIdle),
    .isaClkStop(isaClkStop)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    vectors++;
    if (act < lo || act > hi) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = int'(regRdata);
  endtask

  task automatic waitFall();
    logic prev;
    prev = suspN;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (prev && !suspN) break;
      prev = suspN;
    end
  endtask

  // Counts samples at the given level, starting at the current sample
  task automatic runLen(input logic lvl, output int n);
    n = 0;
    while (suspN == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic countLow(input int samples, output int lows);
    lows = 0;
    for (int i = 0; i < samples; i++) begin
      @(negedge clk);
      if (!suspN) lows++;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int v, n, lows;
    int vals[5] = '{0, 1, 2, 3, 5};
    logic [7:0] addrs[6] = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96};

    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 suspN", int'(suspN), 1);
    check("R1 activeIdle", int'(activeIdle), 0);
    check("R1 isaClkStop", int'(isaClkStop), 0);
    rstN = 1'b1;
    foreach (addrs[i]) begin
      rd(addrs[i], v);
      check("R1 reg reset", v, 0);
    end

    // R2 readback and unmapped offsets
    foreach (addrs[i]) wr(addrs[i], 8'(8'h21 + 8'(i * 3)));
    foreach (addrs[i]) begin
      rd(addrs[i], v);
      check("R2 readback", v, 8'h21 + i * 3);
    end
    wr(8'h81, 8'h55);
    rd(8'h81, v);
    check("R2 unmapped read", v, 0);
    wr(8'h97, 8'hFF);
    rd(8'h96, v);
    check("R2 unmapped write no effect", v, 8'h21 + 15);
    wr(8'h96, 8'h00);

    // R12 status bits
    wr(8'h96, 8'h18);
    @(negedge clk);
    check("R12 activeIdle", int'(activeIdle), 1);
    check("R12 isaClkStop", int'(isaClkStop), 1);
    wr(8'h96, 8'h08);
    @(negedge clk);
    check("R12 activeIdle clear", int'(activeIdle), 0);
    check("R12 isaClkStop set", int'(isaClkStop), 1);
    wr(8'h96, 8'h00);
    wr(8'h80, 8'h01);

    // R4 / R5 sweep of run and idle counts
    foreach (vals[a]) begin
      foreach (vals[b]) begin
        wr(8'h96, 8'h00);
        wr(8'h94, 8'(vals[a]));
        wr(8'h95, 8'(vals[b]));
        wr(8'h96, 8'h01);
        if (vals[a] != 0 && vals[b] != 0) begin
          waitFall();
          runLen(1'b0, n);
          check("R4 idle length", n, vals[b] * TD);
          runLen(1'b1, n);
          check("R4 run length", n, vals[a] * TD);
        end else begin
          countLow(40, lows);
          check("R5 constant level", lows, (vals[b] == 0) ? 0 : 40);
        end
      end
    end

    // R3 either enable bit clear
    wr(8'h94, 8'd3); wr(8'h95, 8'd2);
    wr(8'h80, 8'h00); wr(8'h96, 8'h01);
    countLow(40, lows);
    check("R3 global clear", lows, 0);
    wr(8'h80, 8'h01); wr(8'h96, 8'h00);
    countLow(40, lows);
    check("R3 modulation bit clear", lows, 0);

    // R6 counts change only at a period boundary
    wr(8'h96, 8'h01);
    waitFall();
    runLen(1'b0, n);
    @(negedge clk);
    regAddr = 8'h94; regWdata = 8'd1; regWr = 1'b1;
    @(negedge clk);
    regAddr = 8'h95; regWdata = 8'd4;
    @(negedge clk);
    regWr = 1'b0;
    waitFall();
    runLen(1'b0, n);
    check("R6 old idle kept", n, 2 * TD);
    runLen(1'b1, n);
    check("R6 new run", n, 1 * TD);
    runLen(1'b0, n);
    check("R6 new idle", n, 4 * TD);

    // Speedup: run 3, idle 2, irq hold 2 ms, video hold 1 ms
    wr(8'h94, 8'd3); wr(8'h95, 8'd2);
    wr(8'h8C, 8'd2); wr(8'h8D, 8'd1);
    wr(8'h80, 8'h19);
    waitFall();
    @(negedge clk); irqEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0;
    check("R7 forced high", int'(suspN), 1);
    runLen(1'b1, n);
    checkRange("R7 irq hold window", n, MT * TD + 1 + 3 * TD, 2 * MT * TD + 3 * TD);
    runLen(1'b0, n);
    check("R11 idle after resume", n, 2 * TD);
    runLen(1'b1, n);
    check("R11 run after resume", n, 3 * TD);

    waitFall();
    @(negedge clk); vidEvent = 1'b1;
    @(negedge clk); vidEvent = 1'b0;
    check("R8 forced high", int'(suspN), 1);
    runLen(1'b1, n);
    checkRange("R8 video hold window", n, 1 + 3 * TD, MT * TD + 3 * TD);

    // R10 reload while running
    waitFall();
    @(negedge clk); irqEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0;
    repeat (10) @(negedge clk);
    irqEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0;
    runLen(1'b1, n);
    checkRange("R10 reloaded window", n, MT * TD + 1 + 3 * TD, 2 * MT * TD + 3 * TD);

    // R9 disabled events ignored
    wr(8'h80, 8'h01);
    waitFall();
    @(negedge clk); irqEvent = 1'b1; vidEvent = 1'b1;
    @(negedge clk); irqEvent = 1'b0; vidEvent = 1'b0;
    check("R9 still low", int'(suspN), 0);
    runLen(1'b0, n);
    check("R9 idle unchanged", n, 2 * TD - 2);

    summary();
  end

endmodule